// File: doc/BRIEF.md
# Serial-Port Register Front-End

This block is the software-facing register file of a serial port. A processor reaches it through a simple word-wide read/write port that decodes a 1 KB window. On the line side it hands outgoing characters to a serialiser over a valid/ready byte stream. It takes incoming characters from a deserialiser over a second byte stream, and it throttles that stream with backpressure. It holds one received character at a time and keeps a status word with transmit-empty, transmit-complete and receive-not-empty flags. It drives a single level interrupt for "character waiting".

The status register has unusual write rules. A small written value replaces the whole status word, but the transmit-empty flag always reads back as set. A large written value clears only the flag bits that are zero in that value. Each accepted data write sets the transmit-complete flag again. The baud-rate, second and third control and guard-time registers are plain storage for the line logic. Bit timing, parity and framing are handled elsewhere.

Top module: `usart_fe_top`

## Requirements
- R1: After reset the status word (offset 0x00) reads 0x000000C0, and every other register reads 0. `irq` and `tx_valid` are low, and `rx_ready` is high.
- R2: A character taken from the receive stream is stored only if control bit 13 (unit enable) and bit 2 (receiver enable) of the control register at 0x0C are both set. Otherwise it is consumed and dropped, and status, data and `irq` do not change.
- R3: `rx_ready` is high exactly while status bit 5 (receive-not-empty) is clear. A character offered while that bit is set is not taken, and the held character is kept.
- R4: Storing a character makes it readable at 0x04 and sets status bit 5 on the next cycle. If control bit 5 (receive interrupt enable) is set, `irq` rises on that same cycle.
- R5: A read of 0x04 returns the held character in bits 7:0 with all upper bits zero. From the next cycle status bit 5 and `irq` are clear.
- R6: A status write with a value no greater than 0x3FF makes the status that value with bit 7 forced to 1. A larger value is ANDed into the present status.
- R7: After a status write, `irq` is low if the resulting bit 5 is clear. Otherwise `irq` keeps its level.
- R8: A write to 0x04 with a value below 0xF000 presents its low byte on `tx_data` with `tx_valid` high on the next cycle, and sets status bit 6. A value of 0xF000 or more changes nothing.
- R9: `tx_valid` and `tx_data` hold until a cycle with `tx_ready` high. A newer data write made while a byte is still pending replaces that byte.
- R10: A write to the control register at 0x0C is stored and reads back unchanged. If the new value has bit 5 set and status bit 5 is already set, `irq` rises on the next cycle.
- R11: Offsets 0x08, 0x10, 0x14 and 0x18 are independent 32-bit read/write registers.
- R12: Only the seven word-aligned offsets 0x00 to 0x18 are mapped. Reads anywhere else in the window return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects apply at the clock edge) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, character waiting |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Serialiser accepts the outgoing byte |
| tx_data | output | CHAR_W | Outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block can take an incoming byte |
| rx_data | input | CHAR_W | Incoming byte |

## Verification
The bench builds the block with its defaults, ADDR_W = 10 and CHAR_W = 8. At these values the full 1 KB window decodes, so the bench can probe an offset at its very top (0x3FC), an offset just past the last register (0x1C) and a misaligned offset. The 8-bit character makes the zero upper bits of a data read visible. The bench also drives the status threshold values 0x3FF and 0xF000 from both sides, and it offers characters while the holding register is full.

// File: rtl/usart_fe_pkg.sv
package usart_fe_pkg;
  localparam int REG_W = 32;

  // word indices (byte offset / 4)
  localparam int W_SR   = 0;
  localparam int W_DR   = 1;
  localparam int W_BRR  = 2;
  localparam int W_CR1  = 3;
  localparam int W_CR2  = 4;
  localparam int W_CR3  = 5;
  localparam int W_GTPR = 6;

  // flag positions
  localparam int SR_TXE     = 7;
  localparam int SR_TC      = 6;
  localparam int SR_RXNE    = 5;
  localparam int CR1_UE     = 13;
  localparam int CR1_RXNEIE = 5;
  localparam int CR1_RE     = 2;

  localparam logic [REG_W-1:0] SR_RESET_VAL  = 32'h0000_00C0;
  localparam logic [REG_W-1:0] SR_REPLACE_MAX = 32'h0000_03FF;
  localparam logic [REG_W-1:0] DR_SEND_LIMIT  = 32'h0000_F000;
  localparam logic [REG_W-1:0] DR_READ_MASK   = 32'h0000_03FF;

  // status after a software write: replace (TXE forced) or AND mask
  function automatic logic [REG_W-1:0] sr_after_write(input logic [REG_W-1:0] cur,
                                                      input logic [REG_W-1:0] val);
    logic [REG_W-1:0] r;
    if (val <= SR_REPLACE_MAX) begin
      r = val;
      r[SR_TXE] = 1'b1;
    end else begin
      r = cur & val;
    end
    return r;
  endfunction

  function automatic logic dr_write_sends(input logic [REG_W-1:0] val);
    return val < DR_SEND_LIMIT;
  endfunction

  function automatic logic rx_enabled(input logic [REG_W-1:0] cr1);
    return cr1[CR1_UE] & cr1[CR1_RE];
  endfunction
endpackage

// File: rtl/usart_fe_rxhold.sv
module usart_fe_rxhold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rxne,
  input  logic              enabled,
  output logic              rx_ready,
  output logic              ev_take,
  output logic              ev_store,
  output logic [CHAR_W-1:0] dr_q
);
  assign rx_ready = !rxne;
  assign ev_take  = rx_valid & rx_ready;
  assign ev_store = ev_take & enabled;

  always_ff @(posedge clk) begin
    if (!rst_n) dr_q <= '0;
    else if (ev_store) dr_q <= rx_data;
  end

  AST_RX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(dr_q)); // R3
  AST_RX_DROP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && !enabled) |=> $stable(dr_q)); // R2
  AST_RX_STORE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> (dr_q == $past(rx_data))); // R4
endmodule

// File: rtl/usart_fe_txslot.sv
module usart_fe_txslot #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !load) |=> (tx_valid && $stable(tx_data))); // R9
  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tx_valid); // R8
endmodule

// File: rtl/usart_fe_cfgbank.sv
module usart_fe_cfgbank #(
  parameter int N_REGS = 4,
  parameter int REG_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_REGS-1:0]            wr_sel,
  input  logic [REG_W-1:0]             wdata,
  output logic [N_REGS-1:0][REG_W-1:0] q
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= '0;
      else if (wr_sel[i]) q[i] <= wdata;
    end
  end

  AST_CFG_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R11
endmodule

// File: rtl/usart_fe_top.sv
module usart_fe_top
  import usart_fe_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [CHAR_W-1:0] rx_data
);
  localparam int WORD_W  = ADDR_W - 2;
  localparam int N_PLAIN = 4;

  logic [WORD_W-1:0] word;
  logic aligned;
  logic sel_sr, sel_dr, sel_brr, sel_cr1, sel_cr2, sel_cr3, sel_gtpr;
  logic ev_sr_wr, ev_dr_wr, ev_dr_rd, ev_cr1_wr, ev_rx_take, ev_rx_store;
  logic [REG_W-1:0] sr_q, sr_d, cr1_q, cr1_d;
  logic irq_d;
  logic [CHAR_W-1:0] dr_q;
  logic [N_PLAIN-1:0] plain_sel;
  logic [N_PLAIN-1:0][REG_W-1:0] plain_q;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign sel_sr   = aligned && (word == WORD_W'(W_SR));
  assign sel_dr   = aligned && (word == WORD_W'(W_DR));
  assign sel_brr  = aligned && (word == WORD_W'(W_BRR));
  assign sel_cr1  = aligned && (word == WORD_W'(W_CR1));
  assign sel_cr2  = aligned && (word == WORD_W'(W_CR2));
  assign sel_cr3  = aligned && (word == WORD_W'(W_CR3));
  assign sel_gtpr = aligned && (word == WORD_W'(W_GTPR));

  // named internal events
  assign ev_sr_wr  = bus_wr && sel_sr;
  assign ev_dr_wr  = bus_wr && sel_dr && dr_write_sends(bus_wdata);
  assign ev_dr_rd  = bus_rd && sel_dr;
  assign ev_cr1_wr = bus_wr && sel_cr1;
  assign plain_sel = {sel_gtpr, sel_cr3, sel_cr2, sel_brr} & {N_PLAIN{bus_wr}};

  usart_fe_rxhold #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rxne(sr_q[SR_RXNE]), .enabled(rx_enabled(cr1_q)), .rx_ready(rx_ready),
    .ev_take(ev_rx_take), .ev_store(ev_rx_store), .dr_q(dr_q)
  );

  usart_fe_txslot #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(ev_dr_wr), .load_data(bus_wdata[CHAR_W-1:0]),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  usart_fe_cfgbank #(.N_REGS(N_PLAIN), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_sel(plain_sel), .wdata(bus_wdata), .q(plain_q)
  );

  // bus effects first, then a stored character (which wins on RXNE)
  always_comb begin
    sr_d  = sr_q;
    cr1_d = cr1_q;
    irq_d = irq;
    if (ev_sr_wr) begin
      sr_d = sr_after_write(sr_q, bus_wdata);
      if (!sr_d[SR_RXNE]) irq_d = 1'b0;
    end
    if (ev_dr_rd) begin
      sr_d[SR_RXNE] = 1'b0;
      irq_d = 1'b0;
    end
    if (ev_dr_wr) sr_d[SR_TC] = 1'b1;
    if (ev_cr1_wr) begin
      cr1_d = bus_wdata;
      if (bus_wdata[CR1_RXNEIE] && sr_q[SR_RXNE]) irq_d = 1'b1;
    end
    if (ev_rx_store) begin
      sr_d[SR_RXNE] = 1'b1;
      if (cr1_q[CR1_RXNEIE]) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= SR_RESET_VAL;
      cr1_q <= '0;
      irq   <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cr1_q <= cr1_d;
      irq   <= irq_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_sr)   bus_rdata = sr_q;
    if (sel_dr)   bus_rdata = REG_W'(dr_q) & DR_READ_MASK;
    if (sel_brr)  bus_rdata = plain_q[0];
    if (sel_cr1)  bus_rdata = cr1_q;
    if (sel_cr2)  bus_rdata = plain_q[1];
    if (sel_cr3)  bus_rdata = plain_q[2];
    if (sel_gtpr) bus_rdata = plain_q[3];
  end

  AST_RX_STORE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_store && cr1_q[CR1_RXNEIE]) |=> (irq && sr_q[SR_RXNE])); // R4
  AST_DR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dr_rd && !ev_rx_store) |=> (!irq && !sr_q[SR_RXNE])); // R5
  AST_SR_SMALL_TXE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sr_wr && (bus_wdata <= SR_REPLACE_MAX)) |=> sr_q[SR_TXE]); // R6
  AST_SR_WR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sr_wr && !ev_rx_store) |=> (sr_q[SR_RXNE] || !irq)); // R7
  AST_DR_WR_TC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dr_wr |=> sr_q[SR_TC]); // R8
  AST_CR1_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cr1_wr && bus_wdata[CR1_RXNEIE] && sr_q[SR_RXNE]) |=> irq); // R10
endmodule

// File: tb/usart_fe_top_tb_top.sv
`timescale 1ns/1ps
module usart_fe_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, tx_valid, rx_ready;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0]  tx_data;
  logic [7:0]  rx_data = '0;

  int checks = 0;
  int fails = 0;
  logic [31:0] last_rd;

  // behavioural reference state
  logic [31:0] m_sr, m_cr1;
  logic [31:0] m_plain [4];
  logic [7:0]  m_dr, m_txd;
  bit          m_irq, m_txv;

  always #2 clk = ~clk;

  usart_fe_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [9:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (int'(a[9:2]))
      0: return m_sr;
      1: return {24'h0, m_dr};
      2: return m_plain[0];
      3: return m_cr1;
      4: return m_plain[1];
      5: return m_plain[2];
      6: return m_plain[3];
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_reset();
    m_sr = 32'hC0; m_cr1 = 0; m_dr = 0; m_irq = 0; m_txv = 0; m_txd = 0;
    foreach (m_plain[i]) m_plain[i] = 0;
  endtask

  // one clock: drive, check combinational, advance model, check registered
  task automatic cyc(input string tag, input bit wr, input bit rd, input logic [9:0] a,
                     input logic [31:0] d, input bit rxv, input logic [7:0] rxd,
                     input bit txr);
    logic [31:0] n_sr;
    bit n_irq;
    bit mapped;
    int w;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    rx_valid = rxv; rx_data = rxd; tx_ready = txr;
    #1;
    chk(tag, "rx_ready", {31'b0, rx_ready}, {31'b0, !m_sr[5]});
    if (rd) begin
      last_rd = bus_rdata;
      chk(tag, "rdata", bus_rdata, m_read(a));
    end
    n_sr = m_sr; n_irq = m_irq;
    mapped = (a[1:0] == 2'b00);
    w = int'(a[9:2]);
    if (m_txv && txr) m_txv = 0;
    if (wr && mapped) begin
      if (w == 0) begin
        n_sr = (d <= 32'h3FF) ? (d | 32'h80) : (m_sr & d);
        if (!n_sr[5]) n_irq = 0;
      end else if (w == 1 && d < 32'hF000) begin
        m_txv = 1; m_txd = d[7:0]; n_sr[6] = 1;
      end else if (w == 3) begin
        if (d[5] && m_sr[5]) n_irq = 1;
      end
    end
    if (rd && mapped && w == 1) begin
      n_sr[5] = 0; n_irq = 0;
    end
    if (rxv && !m_sr[5] && m_cr1[13] && m_cr1[2]) begin
      m_dr = rxd; n_sr[5] = 1;
      if (m_cr1[5]) n_irq = 1;
    end
    if (wr && mapped) begin
      if (w == 3) m_cr1 = d;
      if (w == 2) m_plain[0] = d;
      if (w == 4) m_plain[1] = d;
      if (w == 5) m_plain[2] = d;
      if (w == 6) m_plain[3] = d;
    end
    m_sr = n_sr; m_irq = n_irq;
    @(posedge clk);
    #1;
    chk(tag, "irq", {31'b0, irq}, {31'b0, m_irq});
    chk(tag, "tx_valid", {31'b0, tx_valid}, {31'b0, m_txv});
    if (m_txv) chk(tag, "tx_data", {24'b0, tx_data}, {24'b0, m_txd});
  endtask

  task automatic wr_reg(input string tag, input logic [9:0] a, input logic [31:0] d);
    cyc(tag, 1, 0, a, d, 0, 8'h0, 0);
  endtask
  task automatic rd_exp(input string tag, input logic [9:0] a, input logic [31:0] exp);
    cyc(tag, 0, 1, a, 32'h0, 0, 8'h0, 0);
    chk(tag, "literal", last_rd, exp);
  endtask
  task automatic rx_byte(input string tag, input logic [7:0] b);
    cyc(tag, 0, 0, 10'h0, 32'h0, 1, b, 0);
  endtask
  task automatic idle(input string tag, input bit txr);
    cyc(tag, 0, 0, 10'h0, 32'h0, 0, 8'h0, txr);
  endtask

  initial begin
    fork
      begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        chk("R1", "irq", {31'b0, irq}, 32'h0);
        chk("R1", "tx_valid", {31'b0, tx_valid}, 32'h0);
        rd_exp("R1", 10'h000, 32'h0000_00C0);
        rd_exp("R1", 10'h004, 32'h0);
        rd_exp("R1", 10'h00C, 32'h0);
        rd_exp("R1", 10'h018, 32'h0);
        // R2 receive while disabled: consumed and dropped
        rx_byte("R2", 8'h41);
        rd_exp("R2", 10'h000, 32'h0000_00C0);
        wr_reg("R2", 10'h00C, 32'h0000_2000);   // UE only
        rx_byte("R2", 8'h42);
        rd_exp("R2", 10'h000, 32'h0000_00C0);
        // R3 enabled, no interrupt enable; second byte refused while full
        wr_reg("R10", 10'h00C, 32'h0000_2004);
        rx_byte("R3", 8'h5A);
        rx_byte("R3", 8'h33);
        rd_exp("R3", 10'h000, 32'h0000_00E0);
        rd_exp("R5", 10'h004, 32'h0000_005A);
        rd_exp("R5", 10'h000, 32'h0000_00C0);
        // R4 interrupt on store, R5 cleared by read
        wr_reg("R10", 10'h00C, 32'h0000_2024);
        rx_byte("R4", 8'h99);
        chk("R4", "irq set", {31'b0, irq}, 32'h1);
        rd_exp("R5", 10'h004, 32'h0000_0099);
        chk("R5", "irq clear", {31'b0, irq}, 32'h0);
        // R10 enabling interrupt with a character already waiting
        wr_reg("R10", 10'h00C, 32'h0000_2004);
        rx_byte("R10", 8'h11);
        chk("R10", "irq quiet", {31'b0, irq}, 32'h0);
        wr_reg("R10", 10'h00C, 32'h0000_2024);
        chk("R10", "irq raised", {31'b0, irq}, 32'h1);
        rd_exp("R10", 10'h00C, 32'h0000_2024);
        // R7 AND mask keeps RXNE, irq stays; replace clears it
        wr_reg("R7", 10'h000, 32'hFFFF_FFFF);
        chk("R7", "irq kept", {31'b0, irq}, 32'h1);
        wr_reg("R6", 10'h000, 32'h0000_0000);
        chk("R7", "irq dropped", {31'b0, irq}, 32'h0);
        rd_exp("R6", 10'h000, 32'h0000_0080);
        // R6 boundary values
        wr_reg("R6", 10'h000, 32'h0000_03FF);
        rd_exp("R6", 10'h000, 32'h0000_03FF);
        wr_reg("R6", 10'h000, 32'hFFFF_FF0F);
        rd_exp("R6", 10'h000, 32'h0000_030F);
        wr_reg("R6", 10'h000, 32'h0000_0400);
        rd_exp("R6", 10'h000, 32'h0000_0000);
        // R8 send and TC
        wr_reg("R8", 10'h004, 32'h0000_1234);
        chk("R8", "tx byte", {24'b0, tx_data}, 32'h34);
        rd_exp("R8", 10'h000, 32'h0000_0040);
        // R9 hold while not ready, replace while pending, drain
        idle("R9", 0);
        idle("R9", 0);
        chk("R9", "held", {31'b0, tx_valid}, 32'h1);
        wr_reg("R9", 10'h004, 32'h0000_EF56);
        chk("R9", "replaced", {24'b0, tx_data}, 32'h56);
        idle("R9", 1);
        chk("R9", "drained", {31'b0, tx_valid}, 32'h0);
        // R8 ignored values at and above the limit
        wr_reg("R8", 10'h000, 32'h0000_0000);
        wr_reg("R8", 10'h004, 32'h0000_F000);
        wr_reg("R8", 10'h004, 32'hFFFF_FFAA);
        chk("R8", "no send", {31'b0, tx_valid}, 32'h0);
        rd_exp("R8", 10'h000, 32'h0000_0080);
        // R11 plain storage
        wr_reg("R11", 10'h008, 32'h1111_0001);
        wr_reg("R11", 10'h010, 32'h2222_0002);
        wr_reg("R11", 10'h014, 32'h3333_0003);
        wr_reg("R11", 10'h018, 32'h4444_0004);
        rd_exp("R11", 10'h008, 32'h1111_0001);
        rd_exp("R11", 10'h010, 32'h2222_0002);
        rd_exp("R11", 10'h014, 32'h3333_0003);
        rd_exp("R11", 10'h018, 32'h4444_0004);
        // R12 unmapped and misaligned offsets
        wr_reg("R12", 10'h3FC, 32'hDEAD_BEEF);
        wr_reg("R12", 10'h01C, 32'hDEAD_BEEF);
        wr_reg("R12", 10'h00A, 32'hDEAD_BEEF);
        wr_reg("R12", 10'h00D, 32'h0000_0000);
        rd_exp("R12", 10'h3FC, 32'h0);
        rd_exp("R12", 10'h01C, 32'h0);
        rd_exp("R12", 10'h009, 32'h0);
        rd_exp("R12", 10'h008, 32'h1111_0001);
        rd_exp("R12", 10'h00C, 32'h0000_2024);
        rd_exp("R12", 10'h000, 32'h0000_0080);
      end
      begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule